// File: doc/BRIEF.md
# Reloadable Countdown Event Timer

A single-channel countdown timer that a processor uses as a clock-event source. Software programs a period through a small register set on a simple memory-mapped bus clocked by the bus clock. The counter runs on a separate timer clock. When started it loads the programmed period, counts down one step per timer-clock tick and raises a sticky interrupt when it reaches zero. In periodic mode it reloads the period and goes on; in one-shot mode it stays at zero.

The live counter is never written by software. The period register accepts writes only while the timer is fully stopped. A stop request needs two timer-clock ticks to settle in the counting domain. A start request that arrives during that window is held and applied once the window closes, so it is never lost. The running count is passed back to the bus domain through a request/acknowledge snapshot, so a read never returns a torn value.

Register map (word addresses on `bus_addr_i`): 0 = control/status, 1 = period, 2 = live count (read-only).

Top module: `evt_timer`

## Requirements
- R1: After reset, control reads 0, period reads 0, live count reads 0 and `irq_o` is low.
- R2: A write to address 1 while control bit 0 (start) is clear and control bit 3 (settling) is clear stores the value, and address 1 reads it back.
- R3: A write to address 1 while start is set, or while settling is set, is ignored, and the stored period keeps its old value.
- R4: Setting start loads the period into the counter after synchronisation. The counter then drops by one per timer-clock tick, and the interrupt is raised one period of ticks later, plus at most a few ticks of crossing delay. With control bit 1 (periodic) clear, the counter stays at zero afterwards.
- R5: With periodic set, the counter reloads the period on the tick after reaching zero. Successive interrupts are therefore exactly period+1 timer-clock ticks apart.
- R6: The pending flag is control bit 2 and drives `irq_o`. It stays set until software writes a 1 to bit 2. Writing a 0 there leaves it set. A new event in the same cycle as a clear wins.
- R7: After start is cleared, control bit 3 reads 1 until the counting domain has seen the stop for at least two timer-clock ticks. A start write made meanwhile reads back as 1 at once and is applied once the window closes.
- R8: The live count seen at address 2 during a one-shot run never exceeds the period and never increases.
- R9: A period of 0 never raises the interrupt, in either mode.
- R10: While stopped, the live count holds the value it had when counting stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| tclk_i | input | 1 | Timer (counting) clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write enable (1 = write) |
| bus_addr_i | input | 2 | Word address: 0 control, 1 period, 2 live count |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from address |
| irq_o | output | 1 | Interrupt, high while the pending flag is set |

## Verification
Bus-domain register effects are due one bus edge after the write strobe. The settling flag is due two bus edges after a stop write, so each check reads one full access later. Counter-driven results cross domains at unknown phase: the start reaches the counter after 2 to 3 timer ticks, and an event reaches `irq_o` within 3 bus edges. For that reason the interrupt time and the periodic spacing are checked against windows measured in timer-clock periods, not against single edges. Snapshot reads of the live count lag by a few ticks, so they are compared only for bounds, for monotonicity, or after the counter has been stopped long enough to be stable.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_INTV = 2'd1;
  localparam logic [1:0] ADDR_CUR  = 2'd2;

  localparam int BIT_EN     = 0;
  localparam int BIT_RL     = 1;
  localparam int BIT_PEND   = 2;
  localparam int BIT_SETTLE = 3;
endpackage

// File: rtl/evt_timer_sync.sv
module evt_timer_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st_q[g] <= '0;
        else         st_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st_q[g] <= '0;
        else         st_q[g] <= st_q[g-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core #(
  parameter int CNT_W        = 32,
  parameter int SETTLE_TICKS = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             tclk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             rl_i,
  input  logic [CNT_W-1:0] intv_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             act_o,
  output logic             tgl_o,
  output logic             en_t_o,
  output logic             en_d_o,
  output logic             rl_t_o
);
  localparam int SW = $clog2(SETTLE_TICKS + 1);
  localparam logic [SW-1:0] SETTLE_END = SW'(SETTLE_TICKS);

  logic             en_t, rl_t, en_d_q, act_q, tgl_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SW-1:0]    settle_q;

  evt_timer_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync_ctl (
    .clk_i (tclk_i),
    .rst_ni(rst_ni),
    .d_i   ({en_i, rl_i}),
    .q_o   ({en_t, rl_t})
  );

  always_ff @(posedge tclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_d_q <= 1'b0;
      cnt_q  <= '0;
      tgl_q  <= 1'b0;
    end else begin
      en_d_q <= en_t;
      if (en_t && !en_d_q) begin
        cnt_q <= intv_i;
      end else if (en_t) begin
        if (cnt_q != '0) begin
          cnt_q <= cnt_q - CNT_W'(1);
          if (cnt_q == CNT_W'(1)) tgl_q <= ~tgl_q;
        end else if (rl_t) begin
          cnt_q <= intv_i;
        end
      end
    end
  end

  // ticks since the stop was seen; active until the window has passed
  always_ff @(posedge tclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      settle_q <= SETTLE_END;
      act_q    <= 1'b0;
    end else begin
      if (en_t)                       settle_q <= '0;
      else if (settle_q != SETTLE_END) settle_q <= settle_q + SW'(1);
      act_q <= en_t || (settle_q != SETTLE_END);
    end
  end

  assign cnt_o  = cnt_q;
  assign act_o  = act_q;
  assign tgl_o  = tgl_q;
  assign en_t_o = en_t;
  assign en_d_o = en_d_q;
  assign rl_t_o = rl_t;
endmodule

// File: rtl/evt_timer_snap.sv
module evt_timer_snap #(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             tclk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] cur_o
);
  logic             req_q, req_t, ack_q, ack_s;
  logic [CNT_W-1:0] hold_q, cur_q;

  evt_timer_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_req (
    .clk_i(tclk_i), .rst_ni(rst_ni), .d_i(req_q), .q_o(req_t)
  );
  evt_timer_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_ack (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ack_q), .q_o(ack_s)
  );

  always_ff @(posedge tclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      ack_q  <= 1'b0;
    end else if (req_t != ack_q) begin
      hold_q <= cnt_i;
      ack_q  <= req_t;
    end
  end

  // hold_q is stable whenever ack_s equals req_q
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      req_q <= 1'b0;
    end else if (ack_s == req_q) begin
      cur_q <= hold_q;
      req_q <= ~req_q;
    end
  end

  assign cur_o = cur_q;
endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
  import evt_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              act_s_i,
  input  logic              evt_s_i,
  input  logic [CNT_W-1:0]  cur_i,
  output logic              en_req_o,
  output logic              en_o,
  output logic              rl_o,
  output logic              pend_o,
  output logic [CNT_W-1:0]  intv_o
);
  logic             en_req_q, en_q, rl_q, pend_q, evt_prev_q;
  logic [CNT_W-1:0] intv_q;
  logic             wr_ctrl, wr_intv, settling, evt_hit;

  assign settling = en_q ^ act_s_i;
  assign evt_hit  = evt_s_i ^ evt_prev_q;
  assign wr_ctrl  = bus_sel_i && bus_we_i && (bus_addr_i == ADDR_CTRL);
  assign wr_intv  = bus_sel_i && bus_we_i && (bus_addr_i == ADDR_INTV)
                    && !en_req_q && !en_q && !act_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_req_q   <= 1'b0;
      rl_q       <= 1'b0;
      en_q       <= 1'b0;
      pend_q     <= 1'b0;
      evt_prev_q <= 1'b0;
      intv_q     <= '0;
    end else begin
      if (wr_ctrl) begin
        en_req_q <= bus_wdata_i[BIT_EN];
        rl_q     <= bus_wdata_i[BIT_RL];
      end
      if (wr_intv) intv_q <= bus_wdata_i[CNT_W-1:0];
      // a level change is passed on only after the previous one completed
      if (en_req_q && !en_q && !act_s_i)      en_q <= 1'b1;
      else if (!en_req_q && en_q && act_s_i)  en_q <= 1'b0;
      evt_prev_q <= evt_s_i;
      if (evt_hit)                                pend_q <= 1'b1;
      else if (wr_ctrl && bus_wdata_i[BIT_PEND])  pend_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      ADDR_CTRL: begin
        bus_rdata_o[BIT_EN]     = en_req_q;
        bus_rdata_o[BIT_RL]     = rl_q;
        bus_rdata_o[BIT_PEND]   = pend_q;
        bus_rdata_o[BIT_SETTLE] = settling;
      end
      ADDR_INTV: bus_rdata_o[CNT_W-1:0] = intv_q;
      ADDR_CUR:  bus_rdata_o[CNT_W-1:0] = cur_i;
      default:   bus_rdata_o = '0;
    endcase
  end

  assign en_req_o = en_req_q;
  assign en_o     = en_q;
  assign rl_o     = rl_q;
  assign pend_o   = pend_q;
  assign intv_o   = intv_q;
endmodule

// File: rtl/evt_timer.sv
module evt_timer #(
  parameter int DATA_W       = 32,
  parameter int CNT_W        = 32,
  parameter int SETTLE_TICKS = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk_i,
  input  logic              tclk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  logic             en_req, en_q, rl_q, pend;
  logic             act_t, tgl_t, act_s, evt_s;
  logic             en_t, en_d, rl_t;
  logic [CNT_W-1:0] intv, cnt, cur;

  evt_timer_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_sel_i  (bus_sel_i),
    .bus_we_i   (bus_we_i),
    .bus_addr_i (bus_addr_i),
    .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o),
    .act_s_i    (act_s),
    .evt_s_i    (evt_s),
    .cur_i      (cur),
    .en_req_o   (en_req),
    .en_o       (en_q),
    .rl_o       (rl_q),
    .pend_o     (pend),
    .intv_o     (intv)
  );

  evt_timer_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync_back (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({act_t, tgl_t}),
    .q_o   ({act_s, evt_s})
  );

  evt_timer_core #(
    .CNT_W(CNT_W), .SETTLE_TICKS(SETTLE_TICKS), .SYNC_STAGES(SYNC_STAGES)
  ) u_core (
    .tclk_i(tclk_i),
    .rst_ni(rst_ni),
    .en_i  (en_q),
    .rl_i  (rl_q),
    .intv_i(intv),
    .cnt_o (cnt),
    .act_o (act_t),
    .tgl_o (tgl_t),
    .en_t_o(en_t),
    .en_d_o(en_d),
    .rl_t_o(rl_t)
  );

  evt_timer_snap #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_snap (
    .clk_i (clk_i),
    .tclk_i(tclk_i),
    .rst_ni(rst_ni),
    .cnt_i (cnt),
    .cur_o (cur)
  );

  assign irq_o = pend;
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk_i,
  input logic              tclk_i,
  input logic              rst_ni,
  input logic              bus_sel_i,
  input logic              bus_we_i,
  input logic [1:0]        bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic              irq_o,
  input logic              en_req,
  input logic              en_q,
  input logic              act_s,
  input logic [CNT_W-1:0]  intv,
  input logic [CNT_W-1:0]  cnt,
  input logic              en_t,
  input logic              en_d,
  input logic              rl_t
);
  assert_intv_locked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_req || en_q || act_s) |=> $stable(intv));

  assert_w1c_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(bus_sel_i && bus_we_i && bus_addr_i == 2'd0 && bus_wdata_i[2]));

  assert_start_waits_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_q) |-> !$past(act_s));

  assert_stop_after_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_q) |-> $past(act_s));

  assert_count_step_R4: assert property (@(posedge tclk_i) disable iff (!rst_ni)
    (en_t && en_d && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

  assert_oneshot_rest_R4: assert property (@(posedge tclk_i) disable iff (!rst_ni)
    (en_t && en_d && !rl_t && cnt == '0) |=> (cnt == '0));

  assert_frozen_R10: assert property (@(posedge tclk_i) disable iff (!rst_ni)
    !en_t |=> $stable(cnt));
endmodule

bind evt_timer evt_timer_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .tclk_i     (tclk_i),
  .rst_ni     (rst_ni),
  .bus_sel_i  (bus_sel_i),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .irq_o      (irq_o),
  .en_req     (en_req),
  .en_q       (en_q),
  .act_s      (act_s),
  .intv       (intv),
  .cnt        (cnt),
  .en_t       (en_t),
  .en_d       (en_d),
  .rl_t       (rl_t)
);

// File: tb/evt_timer_test.sv
`timescale 1ns/1ps
module evt_timer_test;
  localparam int TP = 42;  // timer clock period, ns

  logic        clk_i = 1'b0, tclk_i = 1'b0, rst_ni = 1'b0;
  logic        bus_sel_i = 1'b0, bus_we_i = 1'b0;
  logic [1:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        irq_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;
  always #(TP/2) tclk_i = ~tclk_i;

  evt_timer uut (
    .clk_i(clk_i), .tclk_i(tclk_i), .rst_ni(rst_ni),
    .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk_i); #1;
    bus_sel_i = 1; bus_we_i = 1; bus_addr_i = a; bus_wdata_i = d;
    @(posedge clk_i); #1;
    bus_sel_i = 0; bus_we_i = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    @(posedge clk_i); #1;
    bus_sel_i = 1; bus_we_i = 0; bus_addr_i = a;
    #1 d = bus_rdata_o;
    bus_sel_i = 0;
  endtask

  task automatic wait_irq(input int max_cyc, output bit hit);
    hit = 0;
    for (int i = 0; i < max_cyc && !hit; i++) begin
      @(posedge clk_i); #1;
      if (irq_o) hit = 1;
    end
  endtask

  task automatic wait_idle(output bit ok);
    logic [31:0] r;
    ok = 0;
    for (int i = 0; i < 500 && !ok; i++) begin
      bus_rd(2'd0, r);
      if (!r[3]) ok = 1;
    end
  endtask

  task automatic t_reset;
    logic [31:0] r;
    bus_rd(2'd0, r); check(r == 0, "R1 ctrl", r, 0);
    bus_rd(2'd1, r); check(r == 0, "R1 period", r, 0);
    bus_rd(2'd2, r); check(r == 0, "R1 count", r, 0);
    check(irq_o == 0, "R1 irq", irq_o, 0);
  endtask

  task automatic t_intv_idle;
    logic [31:0] r;
    bus_wr(2'd1, 32'd20);
    bus_rd(2'd1, r); check(r == 20, "R2 period write idle", r, 20);
  endtask

  task automatic t_oneshot;
    logic [31:0] r; bit hit; time t0, dt;
    t0 = $time;
    bus_wr(2'd0, 32'h1);
    wait_irq(2000, hit);
    dt = $time - t0;
    check(hit, "R4 oneshot irq", hit, 1);
    check(dt >= 20*TP && dt <= 25*TP, "R4 irq time ns", dt, 21*TP);
    #(10*TP);
    bus_rd(2'd2, r); check(r == 0, "R4 stays at zero", r, 0);
    bus_rd(2'd0, r); check(r[2:0] == 3'b101, "R4 ctrl after expiry", r[2:0], 5);
  endtask

  task automatic t_w1c;
    bus_wr(2'd0, 32'h1);
    #10 check(irq_o == 1, "R6 write 0 keeps pending", irq_o, 1);
    bus_wr(2'd0, 32'h5);
    #10 check(irq_o == 0, "R6 write 1 clears", irq_o, 0);
  endtask

  task automatic t_intv_locked;
    logic [31:0] r;
    bus_wr(2'd1, 32'd99);
    bus_rd(2'd1, r); check(r == 20, "R3 ignored while running", r, 20);
  endtask

  task automatic t_settle;
    logic [31:0] r; bit ok; time t0, dt;
    t0 = $time;
    bus_wr(2'd0, 32'h0);
    bus_rd(2'd0, r); check(r[3] == 1, "R7 settling shown", r[3], 1);
    bus_wr(2'd1, 32'd77);
    bus_rd(2'd1, r); check(r == 20, "R3 ignored while settling", r, 20);
    wait_idle(ok);
    dt = $time - t0;
    check(ok && dt >= 2*TP, "R7 window length ns", dt, 2*TP);
    bus_wr(2'd1, 32'd10);
    bus_rd(2'd1, r); check(r == 10, "R2 write after settle", r, 10);
  endtask

  task automatic t_reload;
    bit hit; time t1, dt; bit ok;
    bus_wr(2'd0, 32'h3);
    wait_irq(2000, hit);
    t1 = $time;
    bus_wr(2'd0, 32'h7);
    wait_irq(2000, hit);
    dt = $time - t1;
    check(hit, "R5 second event", hit, 1);
    check(dt >= 11*TP - 10 && dt <= 11*TP + 10, "R5 period ns", dt, 11*TP);
    bus_wr(2'd0, 32'h4);
    wait_idle(ok);
  endtask

  task automatic t_held_start;
    logic [31:0] r; bit hit, ok;
    bus_wr(2'd0, 32'h1);
    wait_irq(2000, hit);
    bus_wr(2'd0, 32'h4);
    bus_wr(2'd0, 32'h1);
    bus_rd(2'd0, r);
    check(r[3] == 1 && r[0] == 1, "R7 start held during window", r[3:0], 9);
    wait_irq(2000, hit);
    check(hit, "R7 held start applied", hit, 1);
    bus_wr(2'd0, 32'h4);
    wait_idle(ok);
  endtask

  task automatic t_zero;
    bit hit, ok;
    bus_wr(2'd1, 32'd0);
    bus_wr(2'd0, 32'h7);
    wait_irq(60*TP/4, hit);
    check(!hit, "R9 zero period periodic", hit, 0);
    bus_wr(2'd0, 32'h0);
    wait_idle(ok);
    bus_wr(2'd0, 32'h1);
    wait_irq(30*TP/4, hit);
    check(!hit, "R9 zero period oneshot", hit, 0);
    bus_wr(2'd0, 32'h0);
    wait_idle(ok);
  endtask

  task automatic t_frozen;
    logic [31:0] r, prev, a, b; bit ok, mono;
    bus_wr(2'd1, 32'd1000);
    bus_wr(2'd0, 32'h1);
    prev = 1000; mono = 1;
    for (int i = 0; i < 8; i++) begin
      #(20*TP);
      bus_rd(2'd2, r);
      if (r > prev) mono = 0;
      prev = r;
    end
    check(mono, "R8 snapshot non-increasing", prev, 1000);
    check(prev < 1000, "R8 snapshot advancing", prev, 999);
    bus_wr(2'd0, 32'h0);
    wait_idle(ok);
    #(10*TP);
    bus_rd(2'd2, a);
    #(50*TP);
    bus_rd(2'd2, b);
    check(a == b, "R10 count held while stopped", b, a);
    check(a > 0 && a < 1000, "R10 held value mid-run", a, 500);
  endtask

  initial begin
    #(150000*4);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #23 rst_ni = 1;
    repeat (4) @(posedge clk_i);
    t_reset;
    t_intv_idle;
    t_oneshot;
    t_w1c;
    t_intv_locked;
    t_settle;
    t_reload;
    t_held_start;
    t_zero;
    t_frozen;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule